// File: doc/BRIEF.md
# Configuration Command Bus Bridge

This block sits behind the decryption stage of a secure configuration channel carried over Ethernet. It takes one plaintext configuration command at a time, decodes whether it is a register read or a register write, and performs that access as a single classic Wishbone master cycle into the chip's internal register space. No processor is involved.

When the bus cycle ends, the block builds a fixed-width response word. The cycle can end with an acknowledge or with a timeout. The response word goes back to the encryption stage so the security header can be added again. A malformed operation code never reaches the bus. A slave that never answers is abandoned after a bounded number of cycles, and the block reports an error status instead.

Top module: `cmd_bus_bridge`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, and `wb_cyc_o` and `wb_stb_o` are 0.
- R2: A command word is 56 bits wide and big-endian: bits [55:48] hold the operation code, [47:32] the register address, and [31:0] the write data. Code 0x52 means read and 0x57 means write. Read commands ignore the data field.
- R3: A write is accepted on a clock edge where both `cmd_valid` and `cmd_ready` are 1. From the next cycle, `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are 1, `wb_sel_o` is all ones, and the address and data from the command are held until the acknowledge edge.
- R4: A read drives the same cycle with `wb_we_o` at 0. The response carries the `wb_dat_i` value sampled on the acknowledge edge.
- R5: The response word is a status byte in [55:48], the address in [47:32] and the data in [31:0]. Status 0x00 means success. The data field is zero for writes and for every error.
- R6: Any other operation code gives status 0x01 in the cycle after acceptance, with no bus cycle at all.
- R7: If no acknowledge arrives, `wb_cyc_o` stays high for exactly TIMEOUT_CYCLES cycles and then drops. The response then carries status 0x02.
- R8: Only one command is in flight at a time. `cmd_ready` stays 0 from acceptance until the response is taken (`rsp_valid` and `rsp_ready` both 1). The response is held stable while it waits.
- R9: An acknowledge in the last cycle of the timeout window wins, and the access completes with status 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_data | input | 56 | Command: code, address, data |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_data | output | 56 | Response: status, address, data |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_sel_o | output | 4 | Byte selects |
| wb_adr_o | output | 16 | Bus address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
Some faults in the control state show up at the ports on the very next clock. A bad state encoding or a wrong operation-code decode either raises a bus cycle that should not exist, or drops `cmd_ready` at the wrong time. A wrong timeout counter shows up as a cycle that is one clock longer or shorter than the window, and the status byte that follows is wrong. A fault in the captured address or data shows up as soon as the bus cycle starts, and again in the response word. The bench keeps its own model of every port and compares it every cycle, so each of these faults is reported within one clock of its first visible effect.

// File: rtl/cmd_bus_bridge.sv
module cmd_bus_bridge #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TIMEOUT_CYCLES = 64,
  parameter logic [7:0] OP_READ = 8'h52,
  parameter logic [7:0] OP_WRITE = 8'h57
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [8+ADDR_W+DATA_W-1:0] cmd_data,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [8+ADDR_W+DATA_W-1:0] rsp_data,
  output logic                       wb_cyc_o,
  output logic                       wb_stb_o,
  output logic                       wb_we_o,
  output logic [DATA_W/8-1:0]        wb_sel_o,
  output logic [ADDR_W-1:0]          wb_adr_o,
  output logic [DATA_W-1:0]          wb_dat_o,
  input  logic [DATA_W-1:0]          wb_dat_i,
  input  logic                       wb_ack_i
);
  localparam int WORD_W = 8 + ADDR_W + DATA_W;
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [7:0] ST_OK = 8'h00;
  localparam logic [7:0] ST_BADOP = 8'h01;
  localparam logic [7:0] ST_TIMEOUT = 8'h02;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RSP} state_t;

  state_t            state;
  logic              we_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] dat_q;
  logic [7:0]        status_q;
  logic [TW-1:0]     timer;

  wire [7:0]        op_in  = cmd_data[WORD_W-1 -: 8];
  wire [ADDR_W-1:0] adr_in = cmd_data[DATA_W +: ADDR_W];
  wire [DATA_W-1:0] dat_in = cmd_data[DATA_W-1:0];
  wire op_known = (op_in == OP_READ) || (op_in == OP_WRITE);
  wire last_wait = (timer == TW'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      we_q     <= 1'b0;
      adr_q    <= '0;
      dat_q    <= '0;
      status_q <= ST_OK;
      timer    <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          adr_q <= adr_in;
          we_q  <= (op_in == OP_WRITE);
          dat_q <= (op_in == OP_WRITE) ? dat_in : '0;
          timer <= '0;
          if (op_known) begin
            state <= S_BUS;
          end else begin
            status_q <= ST_BADOP;
            dat_q    <= '0;
            state    <= S_RSP;
          end
        end
        S_BUS: begin
          if (wb_ack_i) begin
            status_q <= ST_OK;
            dat_q    <= we_q ? '0 : wb_dat_i;
            state    <= S_RSP;
          end else if (last_wait) begin
            status_q <= ST_TIMEOUT;
            dat_q    <= '0;
            state    <= S_RSP;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_RSP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RSP);
  assign rsp_data  = {status_q, adr_q, dat_q};
  assign wb_cyc_o  = (state == S_BUS);
  assign wb_stb_o  = (state == S_BUS);
  assign wb_we_o   = (state == S_BUS) && we_q;
  assign wb_sel_o  = '1;
  assign wb_adr_o  = adr_q;
  assign wb_dat_o  = dat_q;
endmodule

module cmd_bus_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TIMEOUT_CYCLES = 64,
  parameter logic [7:0] OP_READ = 8'h52,
  parameter logic [7:0] OP_WRITE = 8'h57
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [8+ADDR_W+DATA_W-1:0] cmd_data,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [8+ADDR_W+DATA_W-1:0] rsp_data,
  input logic                       wb_cyc_o,
  input logic                       wb_stb_o,
  input logic                       wb_we_o,
  input logic [DATA_W/8-1:0]        wb_sel_o,
  input logic [ADDR_W-1:0]          wb_adr_o,
  input logic [DATA_W-1:0]          wb_dat_o,
  input logic                       wb_ack_i
);
  localparam int WORD_W = 8 + ADDR_W + DATA_W;
  localparam int CW = $clog2(TIMEOUT_CYCLES + 2);

  logic [CW-1:0] cyc_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_run <= '0;
    else if (wb_cyc_o) cyc_run <= cyc_run + 1'b1;
    else cyc_run <= '0;
  end

  wire [7:0] op_in = cmd_data[WORD_W-1 -: 8];
  wire bad_op = (op_in != OP_READ) && (op_in != OP_WRITE);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cmd_ready && !rsp_valid && !wb_cyc_o);
  a_r3_strobe_with_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> wb_stb_o && (wb_sel_o == '1));
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && !wb_ack_i && (cyc_run < CW'(TIMEOUT_CYCLES - 1))) |=>
      wb_cyc_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o));
  a_r6_no_bus_for_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && bad_op) |=> !wb_cyc_o && rsp_valid && (rsp_data[WORD_W-1 -: 8] == 8'h01));
  a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> (cyc_run < CW'(TIMEOUT_CYCLES)));
  a_r8_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !wb_cyc_o && !rsp_valid);
  a_r8_response_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
endmodule

bind cmd_bus_bridge cmd_bus_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
  .OP_READ(OP_READ), .OP_WRITE(OP_WRITE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
  .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o), .wb_adr_o(wb_adr_o),
  .wb_dat_o(wb_dat_o), .wb_ack_i(wb_ack_i)
);

// File: tb/tb_cmd_bus_bridge.sv
module tb_cmd_bus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, rsp_ready = 0;
  logic [55:0] cmd_data = '0;
  logic cmd_ready, rsp_valid, wb_cyc, wb_stb, wb_we, wb_ack;
  logic [55:0] rsp_data;
  logic [3:0] wb_sel;
  logic [15:0] wb_adr;
  logic [31:0] wb_dat_o, wb_dat_i;

  int checks = 0, fails = 0, cycles = 0;

  cmd_bus_bridge #(.TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .wb_cyc_o(wb_cyc), .wb_stb_o(wb_stb), .wb_we_o(wb_we),
    .wb_sel_o(wb_sel), .wb_adr_o(wb_adr), .wb_dat_o(wb_dat_o),
    .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack));

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model
  logic [31:0] smem [16];
  int lat = 0;
  int scnt = 0;
  assign wb_ack = wb_cyc && wb_stb && (lat >= 0) && (scnt == lat);
  assign wb_dat_i = smem[wb_adr[3:0]];

  // reference model
  int m_state = 0, m_timer = 0;
  logic m_we = 0;
  logic [15:0] m_adr = 0;
  logic [31:0] m_dat = 0, m_wdat = 0;
  logic [7:0] m_st = 0;
  logic [31:0] mm [16];

  initial for (int i = 0; i < 16; i++) begin
    smem[i] = 32'h1000_0000 + i;
    mm[i] = 32'h1000_0000 + i;
  end

  always @(posedge clk) begin
    if (wb_cyc && wb_stb && !wb_ack) scnt <= scnt + 1;
    else scnt <= 0;
    if (wb_ack && wb_we) smem[wb_adr[3:0]] <= wb_dat_o;
    if (!rst_n) begin
      m_state = 0;
    end else begin
      case (m_state)
        0: if (cmd_valid) begin
          m_adr = cmd_data[47:32];
          m_timer = 0;
          if (cmd_data[55:48] == 8'h57 || cmd_data[55:48] == 8'h52) begin
            m_we = (cmd_data[55:48] == 8'h57);
            m_wdat = cmd_data[31:0];
            m_state = 1;
          end else begin
            m_st = 8'h01; m_dat = 0; m_state = 2;
          end
        end
        1: begin
          if (lat >= 0 && m_timer == lat) begin
            m_st = 8'h00;
            if (m_we) begin mm[m_adr[3:0]] = m_wdat; m_dat = 0; end
            else m_dat = mm[m_adr[3:0]];
            m_state = 2;
          end else if (m_timer == TO - 1) begin
            m_st = 8'h02; m_dat = 0; m_state = 2;
          end else m_timer++;
        end
        default: if (rsp_ready) m_state = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cycles++;
    chk(cmd_ready == (m_state == 0), "R8", "cmd_ready", 64'(cmd_ready), 64'(m_state == 0));
    chk(rsp_valid == (m_state == 2), "R8", "rsp_valid", 64'(rsp_valid), 64'(m_state == 2));
    chk(wb_cyc == (m_state == 1) && wb_stb == (m_state == 1), "R7", "cyc/stb",
        64'({wb_cyc, wb_stb}), 64'({2{m_state == 1}}));
    if (m_state == 1) begin
      chk(wb_we == m_we, m_we ? "R3" : "R4", "we", 64'(wb_we), 64'(m_we));
      chk(wb_sel == 4'hF, "R3", "sel", 64'(wb_sel), 64'hF);
      chk(wb_adr == m_adr, "R2", "adr", 64'(wb_adr), 64'(m_adr));
      if (m_we) chk(wb_dat_o == m_wdat, "R3", "dat_o", 64'(wb_dat_o), 64'(m_wdat));
    end
    if (m_state == 2)
      chk(rsp_data == {m_st, m_adr, m_dat}, "R5", "rsp_data", 64'(rsp_data), 64'({m_st, m_adr, m_dat}));
  end

  int cyc_len = 0;
  always @(negedge clk) begin
    if (wb_cyc) cyc_len++;
    else if (cmd_valid && cmd_ready) cyc_len = 0;
  end

  task automatic run(input logic [7:0] op, input logic [15:0] a, input logic [31:0] d,
                     input int l, input int hold, input logic [55:0] exp_rsp,
                     input int exp_len, input string req);
    lat = l;
    cmd_data = {op, a, d};
    cmd_valid = 1;
    @(negedge clk);
    cmd_data = {8'h57, 16'h0005, 32'hBAD0BAD0};
    while (!rsp_valid) @(negedge clk);
    chk(rsp_data == exp_rsp, req, "response word", 64'(rsp_data), 64'(exp_rsp));
    chk(cyc_len == exp_len, req, "bus cycle length", 64'(cyc_len), 64'(exp_len));
    repeat (hold) @(negedge clk);
    chk(rsp_valid && !cmd_ready, "R8", "held response", 64'({rsp_valid, cmd_ready}), 64'b10);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    cmd_valid = 0;
    chk(cmd_ready && !rsp_valid, "R8", "return to idle", 64'({cmd_ready, rsp_valid}), 64'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && !rsp_valid && !wb_cyc && !wb_stb, "R1", "reset outputs",
        64'({cmd_ready, rsp_valid, wb_cyc, wb_stb}), 64'b1000);
    rst_n = 1;
    @(negedge clk);
    // R3 write then R4 readback
    run(8'h57, 16'h0003, 32'hDEADBEEF, 2, 0, {8'h00, 16'h0003, 32'h0}, 3, "R3");
    run(8'h52, 16'h0003, 32'h12345678, 0, 3, {8'h00, 16'h0003, 32'hDEADBEEF}, 1, "R4");
    run(8'h52, 16'h000A, 32'h0, 4, 1, {8'h00, 16'h000A, 32'h1000000A}, 5, "R4");
    // R2 address field position with upper bits set
    run(8'h57, 16'hA5C7, 32'h0BADF00D, 1, 0, {8'h00, 16'hA5C7, 32'h0}, 2, "R2");
    run(8'h52, 16'h0007, 32'h0, 0, 0, {8'h00, 16'h0007, 32'h0BADF00D}, 1, "R2");
    // R6 unknown codes
    run(8'h41, 16'h0001, 32'hFFFFFFFF, 0, 2, {8'h01, 16'h0001, 32'h0}, 0, "R6");
    run(8'h72, 16'h0002, 32'h0, 0, 0, {8'h01, 16'h0002, 32'h0}, 0, "R6");
    // R7 timeout, write not applied
    run(8'h57, 16'h0004, 32'h55555555, -1, 0, {8'h02, 16'h0004, 32'h0}, TO, "R7");
    run(8'h52, 16'h0004, 32'h0, 0, 0, {8'h00, 16'h0004, 32'h10000004}, 1, "R7");
    // R9 ack on final window cycle
    run(8'h52, 16'h0003, 32'h0, TO - 1, 0, {8'h00, 16'h0003, 32'hDEADBEEF}, TO, "R9");
    run(8'h57, 16'h0009, 32'h600DCAFE, TO - 1, 0, {8'h00, 16'h0009, 32'h0}, TO, "R9");
    run(8'h52, 16'h0009, 32'h0, 0, 0, {8'h00, 16'h0009, 32'h600DCAFE}, 1, "R9");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule